// File: doc/BRIEF.md
# Flash Page-Range CRC Signature Engine

This block computes a 24-bit CRC signature over a range of whole 2 KB flash pages so that software can compare it against the signature word kept at the top of that range. Software writes a start address and an end address, then an unlock key, then a command. The engine then fetches every 32-bit word of the range through a simple one-outstanding read port, starting at the lowest word. It skips the final word of the range, because that word holds the stored signature. It feeds each word into the CRC most significant bit first.

While it runs, the engine reports busy and raises a stall request for the bank that holds the range, so that other masters of that bank wait. Each read carries two ECC status bits: one for a corrected error and one for an uncorrectable error. Any event seen during the run is latched into an error flag. That flag is published together with the signature when the run completes, and a one-cycle done pulse marks completion. The number of bits absorbed per clock is a parameter, so the same block can trade hash cycles against logic depth.

Top module: `flash_sig_engine`

## Requirements
- R1: The signature is a 24-bit CRC. It is seeded with 0xFFFFFF at launch. For each data bit d, the register shifts left by one, and the result is XORed with 0x800063 when the old bit 23 XOR d is 1. Each 32-bit word is consumed bit 31 first, and words are consumed from the lowest address upward.
- R2: The low 11 bits of both addresses are ignored. The range covers every word from the first word of the start page through the last word of the end page, inclusive, except the top word at byte offset 0x7FC of the end page. Reads use byte addresses that are multiples of 4 and rise by 4. A one-page range therefore reads 511 words.
- R3: Register writes select a target with wr_sel: 0 is the start address, 1 is the end address, 2 is the key and 3 is the command. A run launches only when wr_sel=2 with data 0xF123F456 is immediately followed, as the next register write, by wr_sel=3 with data 2. Any other write in between, a wrong key or a wrong command code consumes the unlock, and no run starts.
- R4: busy is high from the cycle after the launching write until the cycle in which done is high. A command issued while busy is refused, and the run already in progress completes unaffected.
- R5: A command whose start and end pages lie in different banks (address bit ADDR_W-1 differs), or whose start page is above its end page, is rejected. No read is issued, and the previous signature and error flag are kept.
- R6: While busy, stall_req has exactly one bit set: the bit of the bank holding the range. When idle, stall_req is zero.
- R7: err_flag is 1 after a run during which any read returned rd_ecc_corr or rd_ecc_fatal, and 0 after a clean run. sig and err_flag change only in the cycle in which done is high.
- R8: done is high for exactly one cycle per run, with busy already low and sig holding the new signature.
- R9: rd_req stays high with an unchanged rd_addr until rd_valid is seen. Only one read is outstanding at a time, and rd_req is high only while busy.
- R10: After reset, busy, done, rd_req, stall_req, sig and err_flag are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 start, 1 end, 2 key, 3 command |
| wr_data | input | 32 | Write data |
| busy | output | 1 | Signature run in progress |
| done | output | 1 | One-cycle completion pulse |
| stall_req | output | NUM_BANKS | Per-bank stall request toward other masters |
| sig | output | 24 | Signature of the last completed run |
| err_flag | output | 1 | ECC event seen during the last completed run |
| rd_req | output | 1 | Read request, held until rd_valid |
| rd_addr | output | ADDR_W | Byte address of the requested word |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 32 | Read data word |
| rd_ecc_corr | input | 1 | Corrected ECC event on this read |
| rd_ecc_fatal | input | 1 | Uncorrectable ECC event on this read |

## Verification
The bound checker watches, on every cycle, the properties that depend only on the ports. These are the single-bank stall pattern tied to busy, the one-cycle done pulse with busy already low, the read handshake holding its address until valid, word-aligned read addresses, and sig and err_flag staying put outside done. The CRC value, the exact set of words read, the unlock sequence with its cancellation paths, the refusal of commands while busy and the rejection of bad ranges all depend on a whole run. Those are shown only by the bench scenarios, which compare against a reference CRC computed in the bench over its own model of the flash contents.

// File: rtl/flash_sig_pkg.sv
package flash_sig_pkg;
   localparam int          CRC_W      = 24;
   localparam logic [23:0] CRC_POLY   = 24'h800063;
   localparam logic [23:0] CRC_SEED   = 24'hFFFFFF;
   localparam logic [31:0] UNLOCK_KEY = 32'hF123F456;
   localparam logic [31:0] CMD_SIGN   = 32'h0000_0002;

   localparam logic [1:0] SEL_START = 2'd0;
   localparam logic [1:0] SEL_END   = 2'd1;
   localparam logic [1:0] SEL_KEY   = 2'd2;
   localparam logic [1:0] SEL_CMD   = 2'd3;

   typedef enum logic [1:0] {
      FS_IDLE  = 2'd0,
      FS_FETCH = 2'd1,
      FS_HASH  = 2'd2
   } fsig_state_e;
endpackage

// File: rtl/fsig_crc_step.sv
// Absorbs STEP_BITS data bits (MSB first) into the CRC in one cycle.
module fsig_crc_step
   import flash_sig_pkg::*;
#(
   parameter int STEP_BITS = 32
) (
   input  logic [CRC_W-1:0]     crc_in,
   input  logic [STEP_BITS-1:0] data_in,
   output logic [CRC_W-1:0]     crc_out
);
   logic [CRC_W-1:0] chain [STEP_BITS+1];

   assign chain[0] = crc_in;

   for (genvar i = 0; i < STEP_BITS; i++) begin : g_bit
      logic fb;
      assign fb          = chain[i][CRC_W-1] ^ data_in[STEP_BITS-1-i];
      assign chain[i+1]  = {chain[i][CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
   end

   assign crc_out = chain[STEP_BITS];
endmodule

// File: rtl/fsig_launch.sv
// Address capture, key/command unlock and range validation.
module fsig_launch
   import flash_sig_pkg::*;
#(
   parameter int ADDR_W   = 18,
   parameter int PAGE_LSB = 11,
   parameter int BANK_W   = 1,
   parameter int PAGE_W   = ADDR_W - PAGE_LSB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [31:0]       wr_data,
   input  logic              busy,
   output logic              launch,
   output logic [PAGE_W-1:0] first_page,
   output logic [PAGE_W-1:0] last_page
);
   logic armed;
   logic range_ok;
   logic cmd_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed      <= 1'b0;
         first_page <= '0;
         last_page  <= '0;
      end else if (wr_en) begin
         armed <= (wr_sel == SEL_KEY) && (wr_data == UNLOCK_KEY);
         if (wr_sel == SEL_START) first_page <= wr_data[ADDR_W-1:PAGE_LSB];
         if (wr_sel == SEL_END)   last_page  <= wr_data[ADDR_W-1:PAGE_LSB];
      end
   end

   assign range_ok = (first_page[PAGE_W-1 -: BANK_W] == last_page[PAGE_W-1 -: BANK_W])
                     && (first_page <= last_page);
   assign cmd_hit  = wr_en && (wr_sel == SEL_CMD) && (wr_data == CMD_SIGN);
   assign launch   = cmd_hit && armed && !busy && range_ok;
endmodule

// File: rtl/flash_sig_engine.sv
module flash_sig_engine
   import flash_sig_pkg::*;
#(
   parameter int ADDR_W    = 18,
   parameter int NUM_BANKS = 2,
   parameter int STEP_BITS = 32,
   parameter int PAGE_LSB  = 11
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [1:0]           wr_sel,
   input  logic [31:0]          wr_data,
   output logic                 busy,
   output logic                 done,
   output logic [NUM_BANKS-1:0] stall_req,
   output logic [23:0]          sig,
   output logic                 err_flag,
   output logic                 rd_req,
   output logic [ADDR_W-1:0]    rd_addr,
   input  logic                 rd_valid,
   input  logic [31:0]          rd_data,
   input  logic                 rd_ecc_corr,
   input  logic                 rd_ecc_fatal
);
   localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
   localparam int PAGE_W = ADDR_W - PAGE_LSB;
   localparam int WORD_W = ADDR_W - 2;
   localparam int WIP    = PAGE_LSB - 2;
   localparam int BEATS  = 32 / STEP_BITS;
   localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;

   if (NUM_BANKS < 2 || (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two, at least 2");
   end
   if (STEP_BITS < 1 || STEP_BITS > 32 || (32 % STEP_BITS) != 0) begin : g_bad_step
      $error("STEP_BITS must divide 32");
   end
   if (ADDR_W > 32 || ADDR_W <= PAGE_LSB + BANK_W) begin : g_bad_addr
      $error("ADDR_W must leave room for bank and page bits and fit 32");
   end
   if (PAGE_LSB < 4) begin : g_bad_page
      $error("PAGE_LSB must be at least 4");
   end

   fsig_state_e         state;
   logic [WORD_W-1:0]   cur_word;
   logic [WORD_W-1:0]   last_word;
   logic [31:0]         wbuf;
   logic [BEAT_W-1:0]   beat;
   logic [CRC_W-1:0]    crc_q;
   logic [CRC_W-1:0]    crc_next;
   logic                err_acc;
   logic [BANK_W-1:0]   bank_q;
   logic                launch;
   logic [PAGE_W-1:0]   first_page;
   logic [PAGE_W-1:0]   last_page;
   logic                last_beat;

   fsig_launch #(
      .ADDR_W   (ADDR_W),
      .PAGE_LSB (PAGE_LSB),
      .BANK_W   (BANK_W),
      .PAGE_W   (PAGE_W)
   ) u_launch (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_sel     (wr_sel),
      .wr_data    (wr_data),
      .busy       (busy),
      .launch     (launch),
      .first_page (first_page),
      .last_page  (last_page)
   );

   fsig_crc_step #(
      .STEP_BITS (STEP_BITS)
   ) u_step (
      .crc_in  (crc_q),
      .data_in (wbuf[31 -: STEP_BITS]),
      .crc_out (crc_next)
   );

   assign last_beat = (beat == BEAT_W'(BEATS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= FS_IDLE;
         cur_word  <= '0;
         last_word <= '0;
         wbuf      <= '0;
         beat      <= '0;
         crc_q     <= '0;
         err_acc   <= 1'b0;
         bank_q    <= '0;
         sig       <= '0;
         err_flag  <= 1'b0;
         done      <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state)
            FS_IDLE: begin
               if (launch) begin
                  cur_word  <= {first_page, {WIP{1'b0}}};
                  last_word <= {last_page, {(WIP-1){1'b1}}, 1'b0};
                  crc_q     <= CRC_SEED;
                  err_acc   <= 1'b0;
                  bank_q    <= first_page[PAGE_W-1 -: BANK_W];
                  state     <= FS_FETCH;
               end
            end
            FS_FETCH: begin
               if (rd_valid) begin
                  wbuf    <= rd_data;
                  err_acc <= err_acc | rd_ecc_corr | rd_ecc_fatal;
                  beat    <= '0;
                  state   <= FS_HASH;
               end
            end
            FS_HASH: begin
               crc_q <= crc_next;
               wbuf  <= wbuf << STEP_BITS;
               beat  <= beat + BEAT_W'(1);
               if (last_beat) begin
                  if (cur_word == last_word) begin
                     state    <= FS_IDLE;
                     done     <= 1'b1;
                     sig      <= crc_next;
                     err_flag <= err_acc;
                  end else begin
                     cur_word <= cur_word + WORD_W'(1);
                     state    <= FS_FETCH;
                  end
               end
            end
            default: state <= FS_IDLE;
         endcase
      end
   end

   assign busy    = (state != FS_IDLE);
   assign rd_req  = (state == FS_FETCH);
   assign rd_addr = {cur_word, 2'b00};

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_stall
      assign stall_req[b] = busy && (bank_q == BANK_W'(b));
   end
endmodule

// File: rtl/fsig_checker.sv
module fsig_checker #(
   parameter int ADDR_W    = 18,
   parameter int NUM_BANKS = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 busy,
   input logic                 done,
   input logic [NUM_BANKS-1:0] stall_req,
   input logic [23:0]          sig,
   input logic                 err_flag,
   input logic                 rd_req,
   input logic [ADDR_W-1:0]    rd_addr,
   input logic                 rd_valid
);
   assert_stall_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (stall_req == '0));

   assert_stall_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> ($countones(stall_req) == 1));

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   assert_done_after_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(busy));

   assert_req_in_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> busy);

   assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));

   assert_addr_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> (rd_addr[1:0] == 2'b00));

   assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(sig) && $stable(err_flag)));
endmodule

bind flash_sig_engine fsig_checker #(
   .ADDR_W    (ADDR_W),
   .NUM_BANKS (NUM_BANKS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .done      (done),
   .stall_req (stall_req),
   .sig       (sig),
   .err_flag  (err_flag),
   .rd_req    (rd_req),
   .rd_addr   (rd_addr),
   .rd_valid  (rd_valid)
);

// File: tb/sim_flash_sig_engine.sv
module sim_flash_sig_engine;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W     = 18;
   localparam int NUM_BANKS  = 2;
   localparam int PAGES_PER_BANK = 64;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 wr_en = 1'b0;
   logic [1:0]           wr_sel = '0;
   logic [31:0]          wr_data = '0;
   logic                 busy, done, err_flag, rd_req;
   logic [NUM_BANKS-1:0] stall_req;
   logic [23:0]          sig;
   logic [ADDR_W-1:0]    rd_addr;
   logic                 rd_valid = 1'b0;
   logic [31:0]          rd_data = '0;
   logic                 rd_ecc_corr = 1'b0;
   logic                 rd_ecc_fatal = 1'b0;

   int    n_checks = 0;
   int    n_errors = 0;
   bit    finished = 1'b0;
   int    rd_count = 0;
   int    first_rd = -1;
   int    last_rd  = -1;
   int    lat      = 0;
   int    inj_addr = -1;
   bit    inj_fatal = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   flash_sig_engine #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .busy(busy), .done(done), .stall_req(stall_req), .sig(sig), .err_flag(err_flag),
      .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
      .rd_ecc_corr(rd_ecc_corr), .rd_ecc_fatal(rd_ecc_fatal)
   );

   function automatic logic [31:0] mem_word(input int a);
      logic [31:0] x = 32'(a);
      return (x * 32'h9E3779B1) ^ 32'h5A5A1234 ^ (x >> 7);
   endfunction

   function automatic logic [23:0] crc_ref(input int sp, input int ep);
      logic [23:0] c = 24'hFFFFFF;
      for (int w = sp * 512; w <= ep * 512 + 510; w++) begin
         logic [31:0] d = mem_word(w * 4);
         for (int b = 31; b >= 0; b--) begin
            logic fb = c[23] ^ d[b];
            c = {c[22:0], 1'b0} ^ (fb ? 24'h800063 : 24'h0);
         end
      end
      return c;
   endfunction

   // flash + ECC model, acts between clock edges
   always @(negedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
      end else if (rd_valid) begin
         rd_valid     <= 1'b0;
         rd_ecc_corr  <= 1'b0;
         rd_ecc_fatal <= 1'b0;
         lat          <= int'($urandom % 3);
      end else if (rd_req) begin
         if (lat == 0) begin
            rd_valid     <= 1'b1;
            rd_data      <= mem_word(int'(rd_addr));
            rd_ecc_corr  <= (int'(rd_addr) == inj_addr) && !inj_fatal;
            rd_ecc_fatal <= (int'(rd_addr) == inj_addr) && inj_fatal;
            if (rd_count == 0) first_rd <= int'(rd_addr);
            last_rd  <= int'(rd_addr);
            rd_count <= rd_count + 1;
         end else begin
            lat <= lat - 1;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] s, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = s; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_done(output bit seen);
      seen = 1'b0;
      for (int i = 0; i < 20000 && !seen; i++) begin
         @(negedge clk);
         if (done) seen = 1'b1;
      end
   endtask

   task automatic sign_ok(input int sa, input int ea, input bit exp_err, input string req);
      int sp = sa >> 11;
      int ep = ea >> 11;
      int bank = sp / PAGES_PER_BANK;
      bit seen;
      logic [23:0] exp_sig = crc_ref(sp, ep);
      rd_count = 0;
      wr(2'd0, 32'(sa));
      wr(2'd1, 32'(ea));
      wr(2'd2, 32'hF123F456);
      wr(2'd3, 32'h2);
      chk(busy === 1'b1, "R4", "busy after launch", longint'(busy), 1);
      chk(stall_req === NUM_BANKS'(1 << bank), "R6", "stall bank", longint'(stall_req),
          longint'(1 << bank));
      wait_done(seen);
      chk(seen, "R8", "done seen", longint'(seen), 1);
      chk(busy === 1'b0, "R8", "busy low at done", longint'(busy), 0);
      chk(sig === exp_sig, req, "signature", longint'(sig), longint'(exp_sig));
      chk(err_flag === exp_err, "R7", "err flag", longint'(err_flag), longint'(exp_err));
      chk(rd_count == (ep - sp + 1) * 512 - 1, "R2", "word count", rd_count,
          (ep - sp + 1) * 512 - 1);
      chk(first_rd == sp * 2048 && last_rd == ep * 2048 + 32'h7F8, "R2", "read span",
          longint'(last_rd), longint'(ep * 2048 + 32'h7F8));
      @(negedge clk);
      chk(done === 1'b0 && stall_req === '0, "R8", "done single pulse / stall dropped",
          longint'({done, stall_req}), 0);
   endtask

   task automatic expect_no_run(input string req, input string what);
      logic [23:0] s0 = sig;
      logic        e0 = err_flag;
      rd_count = 0;
      repeat (4) @(negedge clk);
      chk(busy === 1'b0 && rd_count == 0, req, {what, " no run"}, longint'(busy), 0);
      chk(sig === s0 && err_flag === e0, req, {what, " result kept"}, longint'(sig), longint'(s0));
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      if (!finished) begin
         n_errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin : main
      int seed_init;
      seed_init = int'($urandom(32'd7331));
      repeat (3) @(negedge clk);
      // R10 reset state
      chk(busy === 0 && done === 0 && rd_req === 0 && stall_req === '0, "R10",
          "control reset", longint'({busy, done, rd_req, stall_req}), 0);
      chk(sig === 24'h0 && err_flag === 0, "R10", "result reset", longint'(sig), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1/R2 directed: page 1 from 0x800 / 0x900
      sign_ok(32'h800, 32'h900, 1'b0, "R1");
      // top page of second bank
      sign_ok(127 * 2048 + 5, 127 * 2048 + 32'h7FF, 1'b0, "R1");

      // random ranges, random low address bits
      for (int k = 0; k < 5; k++) begin
         int b  = int'($urandom % 2);
         int sp = b * PAGES_PER_BANK + int'($urandom % 62);
         int ep = sp + int'($urandom % 2);
         sign_ok(sp * 2048 + int'($urandom % 2048), ep * 2048 + int'($urandom % 2048),
                 1'b0, "R1");
      end

      // R7 ECC corrected and uncorrectable events, then a clean run
      inj_addr = 3 * 2048 + 4 * int'($urandom % 511); inj_fatal = 1'b0;
      sign_ok(3 * 2048, 3 * 2048, 1'b1, "R7");
      inj_addr = 70 * 2048 + 2048 + 8; inj_fatal = 1'b1;
      sign_ok(70 * 2048, 71 * 2048, 1'b1, "R7");
      inj_addr = 5 * 2048 + 32'h7FC; inj_fatal = 1'b1;   // excluded word, never read
      sign_ok(5 * 2048, 5 * 2048, 1'b0, "R7");
      inj_addr = -1;

      // R3 unlock cancelled by intervening write, wrong code, missing key
      wr(2'd0, 32'h1000); wr(2'd1, 32'h1000);
      wr(2'd2, 32'hF123F456); wr(2'd0, 32'h1000); wr(2'd3, 32'h2);
      expect_no_run("R3", "write between key and cmd");
      wr(2'd2, 32'hF123F456); wr(2'd3, 32'h1);
      expect_no_run("R3", "wrong cmd code");
      wr(2'd2, 32'hF123F457); wr(2'd3, 32'h2);
      expect_no_run("R3", "wrong key");
      wr(2'd3, 32'h2);
      expect_no_run("R3", "no key");

      // R5 cross-bank and reversed ranges
      wr(2'd0, 63 * 2048); wr(2'd1, 64 * 2048);
      wr(2'd2, 32'hF123F456); wr(2'd3, 32'h2);
      expect_no_run("R5", "cross bank");
      wr(2'd0, 10 * 2048); wr(2'd1, 9 * 2048);
      wr(2'd2, 32'hF123F456); wr(2'd3, 32'h2);
      expect_no_run("R5", "start above end");

      // R4 command while busy is refused
      begin
         bit seen;
         logic [23:0] exp_sig = crc_ref(20, 20);
         rd_count = 0;
         wr(2'd0, 20 * 2048); wr(2'd1, 20 * 2048);
         wr(2'd2, 32'hF123F456); wr(2'd3, 32'h2);
         wr(2'd0, 90 * 2048); wr(2'd1, 91 * 2048);
         wr(2'd2, 32'hF123F456); wr(2'd3, 32'h2);
         chk(stall_req === 2'b01, "R4", "stall kept on first bank", longint'(stall_req), 1);
         wait_done(seen);
         chk(seen && sig === exp_sig, "R4", "first run result", longint'(sig), longint'(exp_sig));
         chk(rd_count == 511, "R4", "first run word count", rd_count, 511);
         repeat (3) @(negedge clk);
         chk(busy === 1'b0, "R4", "no second run", longint'(busy), 0);
      end

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule